// File: doc/BRIEF.md
# Linked-List Sprite Line Scanner

This block prepares the sprite list for the next scanline. Sprite descriptors sit in video memory as a table of 8-byte records. The block does not sweep the table from top to bottom. It starts at record 0 and follows the link byte carried in each record. For every record it visits, it reads four bytes through a single-byte synchronous read port. It then decides whether the sprite's vertical span covers the probe line, which is the current line plus one, wrapped to 8 bits. Each hit is written into a small per-line result list.

The walk is paced from outside. Every `scan_slot` pulse grants a budget of at most two records. The result list fills from its highest position downward, and a hit is written to the position just below the last one used. The walk ends when any of these happens:
- a zero link is read;
- the line's result positions run out;
- a link points at or past the per-frame record limit.

The per-line capacity and the per-frame limit both depend on the display width mode that is latched at `start`. On completion the block holds `done` high and reports the number of hits.

Top module: `sprite_line_scan`

## Requirements
- R1: After reset, `done` is 0, `hit_count` is 0 and no memory read is issued. A `start` pulse latches `wide_mode`, `table_base` and `cur_line`, reloads the result capacity, clears `done`, and makes record 0 the first record visited.
- R2: Record n is read at address `{table_base, 9'b0} + 8*n`. Its bytes 0, 1, 2 and 3 are requested in that order on consecutive cycles (`vram_re` high), and each byte arrives on `vram_rdata` one cycle after it is requested.
- R3: The sprite's vertical position is `{byte0[1:0], byte1} - 128`. Bits 7..2 of byte 0 are ignored. The value is reported on `slot_y` as an 11-bit two's complement number.
- R4: The sprite height is `((byte2[1:0]) + 1) * 8` pixels. With P = (`cur_line` + 1) mod 256, a record is a hit exactly when y <= P < y + height.
- R5: The next record is `byte3[6:0]`, and byte 3 bit 7 is ignored. A next-record value of 0 ends the walk after the current record has been evaluated.
- R6: Each `scan_slot` pulse accepted while the block waits allows at most two records to be read. A `scan_slot` pulse that arrives while records are still being read has no effect.
- R7: Hits are written with `slot_we` into positions counting down from capacity-1. Each write carries the record index, y and the full byte 2.
- R8: The capacity is 20 in wide mode (`wide_mode` = 1) and 16 in narrow mode. Once it is used up, the walk ends and no further reads are issued.
- R9: Before a record is read, the walk ends without reading it if its index is 80 or more (wide mode) or 64 or more (narrow mode).
- R10: `done` rises when the walk ends and stays high until the next `start`. From then on `hit_count` holds the number of hits written for the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new line walk |
| wide_mode | input | 1 | 1 = wide display (20 per line, 80 per frame) |
| table_base | input | 7 | Descriptor table base, in 512-byte units |
| cur_line | input | 8 | Current line; the probe line is this plus one |
| scan_slot | input | 1 | Grants a budget of up to two records |
| vram_re | output | 1 | Byte read request |
| vram_addr | output | 16 | Byte read address |
| vram_rdata | input | 8 | Read data, one cycle after the request |
| slot_we | output | 1 | Result write strobe |
| slot_wpos | output | 5 | Result position being written |
| slot_index | output | 7 | Record index of the hit |
| slot_y | output | 11 | Vertical position of the hit (two's complement) |
| slot_size | output | 8 | Byte 2 of the hit record |
| hit_count | output | 5 | Hits written for this line |
| done | output | 1 | Walk finished |

## Verification
A sweep places sprites of each height code at every vertical offset from well above the probe line to just below it. This separates the inclusive top edge from the exclusive bottom edge, for all four heights and in both width modes. Long chains of hits tell the wide capacity from the narrow one. Links that land at or beyond the frame limit in one mode but not the other tell the two frame limits apart. Probing line 0 through a wrapped current line, with sprites at negative positions, shows whether the position arithmetic is signed. Noise in the ignored bits of bytes 0 and 3, and a second `scan_slot` pulse sent mid-read, check that those inputs are really ignored. Counting record reads per pulse separates the two-record budget from a walk that runs on unpaced.

// File: rtl/spr_scan_pkg.sv
package spr_scan_pkg;

  typedef enum logic [3:0] {
    SC_IDLE,
    SC_WAIT,
    SC_CHK,
    SC_RD0,
    SC_RD1,
    SC_RD2,
    SC_RD3,
    SC_EVAL,
    SC_FIN
  } scan_state_e;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned REC_SH  = 3;   // 8-byte records
  localparam int unsigned Y_BIAS  = 128;

endpackage

// File: rtl/spr_addr_gen.sv
module spr_addr_gen #(
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned VADDR_W = 16
) (
  input  logic [IDX_W-1:0]   base,
  input  logic [IDX_W-1:0]   rec_idx,
  input  logic [1:0]         byte_sel,
  output logic [VADDR_W-1:0] addr
);
  import spr_scan_pkg::*;

  localparam int unsigned SH = VADDR_W - IDX_W;

  logic [VADDR_W-1:0] base_off;
  logic [VADDR_W-1:0] rec_off;

  always_comb begin
    base_off = {base, {SH{1'b0}}};
    rec_off  = VADDR_W'({rec_idx, {REC_SH{1'b0}}});
    addr     = base_off + rec_off + VADDR_W'(byte_sel);
  end

endmodule

// File: rtl/spr_entry_eval.sv
module spr_entry_eval #(
  parameter int unsigned Y_RAW_W = 10,
  parameter int unsigned LINE_W  = 8
) (
  input  logic [7:0]         attr0,
  input  logic [7:0]         attr1,
  input  logic [7:0]         attr2,
  input  logic [LINE_W-1:0]  probe_line,
  output logic [Y_RAW_W:0]   y_pos,
  output logic               covers
);
  import spr_scan_pkg::*;

  localparam int unsigned Y_W = Y_RAW_W + 1;
  localparam int unsigned CW  = Y_RAW_W + 2;

  logic [Y_RAW_W-1:0]   raw_y;
  logic [2:0]           cells;
  logic signed [CW-1:0] y_c;
  logic signed [CW-1:0] h_c;
  logic signed [CW-1:0] line_c;
  logic signed [CW-1:0] y_end;

  always_comb begin
    raw_y  = {attr0[Y_RAW_W-9:0], attr1};
    y_pos  = Y_W'(raw_y) - Y_W'(Y_BIAS);
    y_c    = {y_pos[Y_W-1], y_pos};
    cells  = {1'b0, attr2[1:0]} + 3'd1;
    h_c    = CW'({cells, 3'b000});
    line_c = CW'(probe_line);
    y_end  = y_c + h_c;
    covers = (y_c <= line_c) && (line_c < y_end);
  end

endmodule

// File: rtl/spr_slot_ctr.sv
module spr_slot_ctr #(
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SLOT_W-1:0] cap_in,
  input  logic              dec,
  output logic [SLOT_W-1:0] free_cnt,
  output logic [SLOT_W-1:0] used_cnt
);

  logic [SLOT_W-1:0] cap_q, cap_n;
  logic [SLOT_W-1:0] free_q, free_n;

  always_comb begin
    cap_n  = cap_q;
    free_n = free_q;
    if (load) begin
      cap_n  = cap_in;
      free_n = cap_in;
    end else if (dec) begin
      free_n = free_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      free_q <= '0;
    end else begin
      cap_q  <= cap_n;
      free_q <= free_n;
    end
  end

  assign free_cnt = free_q;
  assign used_cnt = cap_q - free_q;

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (free_q != '0));

endmodule

// File: rtl/sprite_line_scan.sv
module sprite_line_scan #(
  parameter int unsigned IDX_W        = 7,
  parameter int unsigned LINE_W       = 8,
  parameter int unsigned VADDR_W      = 16,
  parameter int unsigned Y_RAW_W      = 10,
  parameter int unsigned SLOTS_WIDE   = 20,
  parameter int unsigned SLOTS_NARROW = 16,
  parameter int unsigned FRAME_WIDE   = 80,
  parameter int unsigned FRAME_NARROW = 64,
  parameter int unsigned PER_SLOT     = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          wide_mode,
  input  logic [IDX_W-1:0]              table_base,
  input  logic [LINE_W-1:0]             cur_line,
  input  logic                          scan_slot,
  output logic                          vram_re,
  output logic [VADDR_W-1:0]            vram_addr,
  input  logic [7:0]                    vram_rdata,
  output logic                          slot_we,
  output logic [$clog2(SLOTS_WIDE+1)-1:0] slot_wpos,
  output logic [IDX_W-1:0]              slot_index,
  output logic [Y_RAW_W:0]              slot_y,
  output logic [7:0]                    slot_size,
  output logic [$clog2(SLOTS_WIDE+1)-1:0] hit_count,
  output logic                          done
);
  import spr_scan_pkg::*;

  localparam int unsigned SLOT_W = $clog2(SLOTS_WIDE + 1);
  localparam int unsigned LIM_W  = IDX_W + 1;
  localparam int unsigned PS_W   = $clog2(PER_SLOT + 1);

  scan_state_e         state_q, state_n;
  logic [IDX_W-1:0]    idx_q, idx_n;
  logic [PS_W-1:0]     in_slot_q, in_slot_n;
  logic [7:0]          a0_q, a0_n, a1_q, a1_n, a2_q, a2_n;
  logic [IDX_W-1:0]    base_q;
  logic [LINE_W-1:0]   probe_q;
  logic                wide_q;

  logic [1:0]          byte_sel;
  logic                rd_en;
  logic                hit_we;
  logic                covers;
  logic [Y_RAW_W:0]    y_pos;
  logic [LIM_W-1:0]    frame_lim;
  logic [SLOT_W-1:0]   cap_sel;
  logic [SLOT_W-1:0]   free_cnt;
  logic [SLOT_W-1:0]   used_cnt;
  logic [IDX_W-1:0]    link;

  // Configuration latched at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      probe_q <= '0;
      wide_q  <= 1'b0;
    end else if (start) begin
      base_q  <= table_base;
      probe_q <= cur_line + 1'b1;
      wide_q  <= wide_mode;
    end
  end

  assign frame_lim = wide_q    ? LIM_W'(FRAME_WIDE) : LIM_W'(FRAME_NARROW);
  assign cap_sel   = wide_mode ? SLOT_W'(SLOTS_WIDE) : SLOT_W'(SLOTS_NARROW);
  assign link      = vram_rdata[IDX_W-1:0];

  spr_addr_gen #(.IDX_W(IDX_W), .VADDR_W(VADDR_W)) u_addr (
    .base     (base_q),
    .rec_idx  (idx_q),
    .byte_sel (byte_sel),
    .addr     (vram_addr)
  );

  spr_entry_eval #(.Y_RAW_W(Y_RAW_W), .LINE_W(LINE_W)) u_eval (
    .attr0      (a0_q),
    .attr1      (a1_q),
    .attr2      (a2_q),
    .probe_line (probe_q),
    .y_pos      (y_pos),
    .covers     (covers)
  );

  spr_slot_ctr #(.SLOT_W(SLOT_W)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .cap_in   (cap_sel),
    .dec      (hit_we),
    .free_cnt (free_cnt),
    .used_cnt (used_cnt)
  );

  // Next-state logic
  always_comb begin
    state_n   = state_q;
    idx_n     = idx_q;
    in_slot_n = in_slot_q;
    a0_n      = a0_q;
    a1_n      = a1_q;
    a2_n      = a2_q;
    rd_en     = 1'b0;
    byte_sel  = 2'd0;
    hit_we    = 1'b0;
    unique case (state_q)
      SC_WAIT: begin
        if (scan_slot) begin
          state_n   = SC_CHK;
          in_slot_n = '0;
        end
      end
      SC_CHK: begin
        if ({1'b0, idx_q} >= frame_lim) begin
          idx_n   = '0;
          state_n = SC_FIN;
        end else begin
          state_n = SC_RD0;
        end
      end
      SC_RD0: begin
        rd_en    = 1'b1;
        byte_sel = 2'd0;
        state_n  = SC_RD1;
      end
      SC_RD1: begin
        rd_en    = 1'b1;
        byte_sel = 2'd1;
        a0_n     = vram_rdata;
        state_n  = SC_RD2;
      end
      SC_RD2: begin
        rd_en    = 1'b1;
        byte_sel = 2'd2;
        a1_n     = vram_rdata;
        state_n  = SC_RD3;
      end
      SC_RD3: begin
        rd_en    = 1'b1;
        byte_sel = 2'd3;
        a2_n     = vram_rdata;
        state_n  = SC_EVAL;
      end
      SC_EVAL: begin
        hit_we    = covers && !start;
        idx_n     = link;
        in_slot_n = in_slot_q + 1'b1;
        if ((link == '0) || (covers && (free_cnt == SLOT_W'(1))))
          state_n = SC_FIN;
        else if (in_slot_n == PS_W'(PER_SLOT))
          state_n = SC_WAIT;
        else
          state_n = SC_CHK;
      end
      default: ;
    endcase
    if (start) begin
      state_n   = SC_WAIT;
      idx_n     = '0;
      in_slot_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SC_IDLE;
      idx_q     <= '0;
      in_slot_q <= '0;
      a0_q      <= '0;
      a1_q      <= '0;
      a2_q      <= '0;
    end else begin
      state_q   <= state_n;
      idx_q     <= idx_n;
      in_slot_q <= in_slot_n;
      a0_q      <= a0_n;
      a1_q      <= a1_n;
      a2_q      <= a2_n;
    end
  end

  assign vram_re    = rd_en;
  assign slot_we    = hit_we;
  assign slot_wpos  = free_cnt - 1'b1;
  assign slot_index = idx_q;
  assign slot_y     = y_pos;
  assign slot_size  = a2_q;
  assign hit_count  = used_cnt;
  assign done       = (state_q == SC_FIN);

  // Checker state: records opened since the last accepted scan slot
  logic [PS_W:0] rd_since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_since_q <= '0;
    else if (start || (state_q == SC_WAIT && scan_slot))
      rd_since_q <= '0;
    else if (vram_re && vram_addr[2:0] == 3'd0)
      rd_since_q <= rd_since_q + 1'b1;
  end

  p_slot_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_since_q <= (PS_W+1)'(PER_SLOT));

  p_frame_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vram_re |-> ({1'b0, idx_q} < frame_lim));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!vram_re && !slot_we));

  p_addr_in_rec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vram_re |-> (vram_addr[2] == 1'b0));

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_we && !start) |=> (hit_count == $past(hit_count) + 1'b1));

  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

// File: tb/sprite_line_scan_tb.sv
module sprite_line_scan_tb;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        wide_mode;
  logic [6:0]  table_base;
  logic [7:0]  cur_line;
  logic        scan_slot;
  logic        vram_re;
  logic [15:0] vram_addr;
  logic [7:0]  vram_rdata;
  logic        slot_we;
  logic [4:0]  slot_wpos;
  logic [6:0]  slot_index;
  logic [10:0] slot_y;
  logic [7:0]  slot_size;
  logic [4:0]  hit_count;
  logic        done;

  sprite_line_scan u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
    .table_base(table_base), .cur_line(cur_line), .scan_slot(scan_slot),
    .vram_re(vram_re), .vram_addr(vram_addr), .vram_rdata(vram_rdata),
    .slot_we(slot_we), .slot_wpos(slot_wpos), .slot_index(slot_index),
    .slot_y(slot_y), .slot_size(slot_size), .hit_count(hit_count), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] mem [0:2047];
  always_ff @(posedge clk) if (vram_re) vram_rdata <= mem[vram_addr[10:0]];

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Read monitor and result capture
  int  rd0_cnt;
  bit  first_rd;
  int  run_base;
  int  prev_addr;
  bit  got_v [0:19];
  int  got_idx [0:19];
  int  got_y [0:19];
  int  got_sz [0:19];

  always @(negedge clk) begin
    if (rst_n && vram_re) begin
      if (vram_addr[2:0] == 3'd0) rd0_cnt++;
      else chk(int'(vram_addr) == prev_addr + 1, "R2", int'(vram_addr), prev_addr + 1);
      if (first_rd) begin
        chk(int'(vram_addr) == run_base * 512, "R1", int'(vram_addr), run_base * 512);
        first_rd = 1'b0;
      end
      prev_addr = int'(vram_addr);
    end
    if (rst_n && slot_we && slot_wpos < 20) begin
      got_v[slot_wpos]   = 1'b1;
      got_idx[slot_wpos] = int'(slot_index);
      got_y[slot_wpos]   = int'($signed(slot_y));
      got_sz[slot_wpos]  = int'(slot_size);
    end
  end

  // Arithmetic expectation from the requirements
  bit m_v [0:19];
  int m_idx [0:19];
  int m_y [0:19];
  int m_sz [0:19];
  int m_hits, m_visits;

  task automatic model(input int b, input int ln, input bit wd);
    int p, free, lim, idx, a, y, h;
    p = (ln + 1) % 256;
    free = wd ? 20 : 16;
    lim = wd ? 80 : 64;
    idx = 0; m_hits = 0; m_visits = 0;
    for (int i = 0; i < 20; i++) m_v[i] = 1'b0;
    while (idx < lim) begin
      a = (b * 512 + idx * 8) % 2048;
      m_visits++;
      y = (((mem[a] & 3) << 8) | mem[a+1]) - 128;
      h = ((mem[a+2] & 3) + 1) * 8;
      if (y <= p && p < y + h) begin
        free--; m_hits++;
        m_v[free] = 1'b1; m_idx[free] = idx; m_y[free] = y; m_sz[free] = mem[a+2];
      end
      idx = mem[a+3] & 127;
      if (idx == 0 || free == 0) break;
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
  endtask

  task automatic put(input int b, input int idx, input int rawy, input int b2,
                     input int b3, input int noise);
    int a;
    a = (b * 512 + idx * 8) % 2048;
    mem[a]   = 8'((noise & 8'hFC) | ((rawy >> 8) & 3));
    mem[a+1] = 8'(rawy & 255);
    mem[a+2] = 8'(b2);
    mem[a+3] = 8'(b3);
  endtask

  task automatic run_scan(input int b, input int ln, input bit wd, input bit dbl);
    int rem, exp_n, guard;
    model(b, ln, wd);
    for (int i = 0; i < 20; i++) got_v[i] = 1'b0;
    @(negedge clk);
    table_base = 7'(b); cur_line = 8'(ln); wide_mode = wd;
    run_base = b; first_rd = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R1", int'(done), 0);
    rem = m_visits; guard = 0;
    while (!done && guard < 100) begin
      rd0_cnt = 0;
      scan_slot = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 20; k++) begin
        scan_slot = (dbl && k == 3);
        @(negedge clk);
      end
      scan_slot = 1'b0;
      exp_n = (rem < 2) ? rem : 2;
      chk(rd0_cnt == exp_n, "R6", rd0_cnt, exp_n);
      rem = rem - exp_n;
      if (done) chk(rem == 0, "R9", rem, 0);
      guard++;
    end
    repeat (4) @(negedge clk);
    chk(done, "R10", int'(done), 1);
    chk(int'(hit_count) == m_hits, "R10", int'(hit_count), m_hits);
    for (int p = 0; p < 20; p++) begin
      chk(got_v[p] == m_v[p], "R7", int'(got_v[p]), int'(m_v[p]));
      if (m_v[p] && got_v[p]) begin
        chk(got_idx[p] == m_idx[p], "R5", got_idx[p], m_idx[p]);
        chk(got_y[p] == m_y[p], "R3", got_y[p], m_y[p]);
        chk(got_sz[p] == m_sz[p], "R4", got_sz[p], m_sz[p]);
      end
    end
  endtask

  bit finished = 1'b0;

  initial begin
    #3_000_000;
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; scan_slot = 1'b0; wide_mode = 1'b0;
    table_base = '0; cur_line = '0; rd0_cnt = 0; first_rd = 1'b0;
    run_base = 0; prev_addr = 0;
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(!done, "R1", int'(done), 0);
    chk(hit_count == 0, "R1", int'(hit_count), 0);
    chk(!vram_re, "R1", int'(vram_re), 0);

    // Mixed chain with edge-of-span cases and ignored bits (R3, R4, R5)
    clear_mem();
    put(0, 0, 228, 8'hF0, 3, 0);        // y=100 h8: top edge hit
    put(0, 3, 221, 8'h00, 7, 8'hFC);    // y=93 h8: last row hit
    put(0, 7, 220, 8'h00, 5, 0);        // y=92 h8: just above, miss
    put(0, 5, 229, 8'h03, 9, 0);        // y=101: below, miss
    put(0, 9, 198, 8'hA7, 8'h80, 8'hFC);// y=70 h32 hit, link bit7 only
    run_scan(0, 99, 1'b1, 1'b0);
    run_scan(0, 99, 1'b0, 1'b1);

    // Capacity: 30 hits chained (R8)
    clear_mem();
    for (int i = 0; i < 30; i++) put(0, i, 128 + 40, 8'h01, (i == 29) ? 0 : i + 1, 0);
    run_scan(0, 40, 1'b0, 1'b0);
    run_scan(0, 40, 1'b1, 1'b0);

    // Frame limit (R9)
    clear_mem();
    put(0, 0, 128 + 10, 0, 10, 0);
    put(0, 10, 128 + 10, 0, 64, 0);
    put(0, 64, 128 + 10, 0, 80, 0);
    put(0, 80, 128 + 10, 0, 0, 0);
    run_scan(0, 9, 1'b0, 1'b0);
    run_scan(0, 9, 1'b1, 1'b0);

    // Probe line wraps to 0, negative positions (R3, R4)
    clear_mem();
    put(0, 0, 120, 8'h01, 2, 0);   // y=-8 h16 hit
    put(0, 2, 128, 8'h00, 4, 0);   // y=0 hit
    put(0, 4, 129, 8'h00, 6, 0);   // y=1 miss
    put(0, 6, 1023, 8'h03, 8, 0);  // y=895 miss
    put(0, 8, 0, 8'h03, 0, 0);     // y=-128 miss
    run_scan(0, 255, 1'b1, 1'b0);

    // Sweep of height code and offset around the probe line, nonzero base
    for (int s = 0; s < 4; s++) begin
      clear_mem();
      for (int i = 0; i < 36; i++)
        put(1, i, 61 + 128 - 34 + i, 8'h40 | s, (i == 35) ? 0 : i + 1, 0);
      run_scan(1, 60, 1'b1, s[0]);
      run_scan(1, 60, 1'b0, s[1]);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule